// File: doc/BRIEF.md
# Interconnect Error Capture Register Block

This block sits beside a coherent interconnect and records the errors it reports. The fabric signals errors as single-cycle pulses on four lanes, one per error kind: local access error, coherency violation, unavailable target and multicast stash. Every lane carries its own transaction address, source identifier and capture type. The block keeps a sticky detect bit for each kind. It freezes the details of the first unmasked error in a capture record marked by a valid flag.

Software programs two separate controls through a 32-bit register port. The first is a per-kind detection disable. The second is a per-kind interrupt enable, which gates the level interrupt without stopping detection. Software services an error by reading the detect word and writing the same value back. That write clears the reported bits and releases the capture record for the next error.

Top module: `icx_err_capture`

## Requirements
- R1: Reset (synchronous, active high) clears every detect, disable, interrupt-enable and capture field, so all register words read zero and `err_irq` is low on the first cycle after reset.
- R2: Detect word bit i (bit 0 local access error, bit 1 coherency violation, bit 2 unavailable target, bit 3 multicast stash) is set one cycle after a pulse on `ev_hit[i]` whose kind is not disabled, and it stays set until it is cleared.
- R3: A set bit i in the disable word (offset 0x04, bits 3:0) stops a pulse on lane i from setting its detect bit and from loading the capture record.
- R4: `err_irq` is high exactly when some detect bit i and interrupt-enable bit i (offset 0x08, bits 3:0) are both set. Writing zero to the interrupt-enable word drops the interrupt and leaves detection running.
- R5: A write to the detect word (offset 0x00) clears each of bits 3:0 written as one, and clears the capture valid flag when bit 31 is written as one. A detect bit set by a pulse in the same cycle as its clear stays set.
- R6: When the valid flag is clear, or is being cleared in the same cycle, the first unmasked pulse loads its address, source ID, capture type and lane, and sets the flag. While the flag is set, later pulses set detect bits but leave the record unchanged.
- R7: If several unmasked lanes pulse in one cycle, all of their detect bits are set, and the lowest-numbered lane supplies the captured fields.
- R8: Layout of the record: the detect word has the valid flag at bit 31 and the capture type at bits 30:26. Offset 0x0C holds the source ID at bits 25:18. Offset 0x10 holds address bits 39:32 in bits 7:0. Offset 0x14 holds address bits 31:0. Offset 0x18 holds the one-hot captured lane in bits 3:0.
- R9: Reserved bits read zero and unmapped or misaligned offsets read zero. Writes to offsets 0x0C through 0x18, and to unmapped or misaligned offsets, change nothing. The disable and enable words keep only bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_hit | input | 4 | Single-cycle error pulse per kind lane |
| ev_addr | input | 160 | Per-lane 40-bit transaction address, lane i at [40i+39:40i] |
| ev_src | input | 32 | Per-lane 8-bit source ID, lane i at [8i+7:8i] |
| ev_ctype | input | 20 | Per-lane 5-bit capture type, lane i at [5i+4:5i] |
| csr_addr | input | 5 | Register byte offset |
| csr_we | input | 1 | Write strobe for the register port |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for csr_addr (combinational) |
| err_irq | output | 1 | Level interrupt |

## Verification
The bench uses the default parameters: four lanes, a 40-bit address, an 8-bit source ID and a 5-bit capture type. With four lanes, every same-cycle mix of error kinds is reachable, including the lowest-lane priority between any pair. The 40-bit width places real data in the high address word, so the split between the two address words is checked. A pseudo-random phase mixes pulses with clears, disable changes and enable changes. This reaches the cases where a clear and a pulse meet in the same cycle.

// File: rtl/icx_err_pkg.sv
package icx_err_pkg;

    localparam int CSR_W     = 32;
    localparam int VALID_BIT = 31;
    localparam int SRC_LSB   = 18;

    typedef enum logic [2:0] {
        W_DETECT  = 3'd0,
        W_DISABLE = 3'd1,
        W_INTEN   = 3'd2,
        W_ATTR    = 3'd3,
        W_ADDRHI  = 3'd4,
        W_ADDRLO  = 3'd5,
        W_ATTR2   = 3'd6
    } csr_word_e;

    typedef struct packed {
        logic det_w1c;
        logic dis_wr;
        logic inten_wr;
    } csr_wr_t;

    function automatic csr_wr_t decode_write(input logic we, input logic [4:0] addr);
        csr_wr_t w;
        w = '0;
        if (we && addr[1:0] == 2'b00) begin
            case (csr_word_e'(addr[4:2]))
                W_DETECT:  w.det_w1c  = 1'b1;
                W_DISABLE: w.dis_wr   = 1'b1;
                W_INTEN:   w.inten_wr = 1'b1;
                default:   w = '0;
            endcase
        end
        return w;
    endfunction

endpackage

// File: rtl/icx_err_prio.sv
module icx_err_prio #(
    parameter int NK = 4,
    parameter int AW = 40,
    parameter int SW = 8,
    parameter int TW = 5
) (
    input  logic [NK-1:0]    live,
    input  logic [NK*AW-1:0] lane_addr,
    input  logic [NK*SW-1:0] lane_src,
    input  logic [NK*TW-1:0] lane_ctype,
    output logic             found,
    output logic [NK-1:0]    sel,
    output logic [AW-1:0]    pick_addr,
    output logic [SW-1:0]    pick_src,
    output logic [TW-1:0]    pick_ctype
);
    logic [AW-1:0] m_addr  [NK];
    logic [SW-1:0] m_src   [NK];
    logic [TW-1:0] m_ctype [NK];

    always_comb begin
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < NK; i++) begin
            sel[i] = live[i] & ~seen;
            seen   = seen | live[i];
        end
    end

    assign found = |live;

    for (genvar g = 0; g < NK; g++) begin : g_lane
        assign m_addr[g]  = {AW{sel[g]}} & lane_addr[g*AW +: AW];
        assign m_src[g]   = {SW{sel[g]}} & lane_src[g*SW +: SW];
        assign m_ctype[g] = {TW{sel[g]}} & lane_ctype[g*TW +: TW];
    end

    always_comb begin
        pick_addr  = '0;
        pick_src   = '0;
        pick_ctype = '0;
        for (int i = 0; i < NK; i++) begin
            pick_addr  = pick_addr  | m_addr[i];
            pick_src   = pick_src   | m_src[i];
            pick_ctype = pick_ctype | m_ctype[i];
        end
    end

endmodule

// File: rtl/icx_err_regs.sv
module icx_err_regs
    import icx_err_pkg::*;
#(
    parameter int NK = 4,
    parameter int AW = 40,
    parameter int SW = 8,
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NK-1:0] live,
    input  csr_wr_t       wr,
    input  logic [NK-1:0] wr_bits,
    input  logic          wr_valid_bit,
    input  logic          found,
    input  logic [NK-1:0] sel,
    input  logic [AW-1:0] pick_addr,
    input  logic [SW-1:0] pick_src,
    input  logic [TW-1:0] pick_ctype,
    output logic [NK-1:0] det_q,
    output logic [NK-1:0] dis_q,
    output logic [NK-1:0] inten_q,
    output logic          cap_valid,
    output logic [AW-1:0] cap_addr,
    output logic [SW-1:0] cap_src,
    output logic [TW-1:0] cap_ctype,
    output logic [NK-1:0] cap_lane
);
    logic [NK-1:0] clr_bits;
    logic          clr_valid;
    logic          open;

    assign clr_bits  = wr.det_w1c ? wr_bits : '0;
    assign clr_valid = wr.det_w1c & wr_valid_bit;
    assign open      = ~cap_valid | clr_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            det_q   <= '0;
            dis_q   <= '0;
            inten_q <= '0;
        end else begin
            det_q <= (det_q & ~clr_bits) | live;
            if (wr.dis_wr)   dis_q   <= wr_bits;
            if (wr.inten_wr) inten_q <= wr_bits;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_valid <= 1'b0;
            cap_addr  <= '0;
            cap_src   <= '0;
            cap_ctype <= '0;
            cap_lane  <= '0;
        end else if (open && found) begin
            cap_valid <= 1'b1;
            cap_addr  <= pick_addr;
            cap_src   <= pick_src;
            cap_ctype <= pick_ctype;
            cap_lane  <= sel;
        end else if (clr_valid) begin
            cap_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/icx_err_rdmux.sv
module icx_err_rdmux
    import icx_err_pkg::*;
#(
    parameter int NK = 4,
    parameter int AW = 40,
    parameter int SW = 8,
    parameter int TW = 5
) (
    input  logic [4:0]       addr,
    input  logic [NK-1:0]    det_q,
    input  logic [NK-1:0]    dis_q,
    input  logic [NK-1:0]    inten_q,
    input  logic             cap_valid,
    input  logic [AW-1:0]    cap_addr,
    input  logic [SW-1:0]    cap_src,
    input  logic [TW-1:0]    cap_ctype,
    input  logic [NK-1:0]    cap_lane,
    output logic [CSR_W-1:0] rdata
);
    localparam int HI_W = AW - 32;
    localparam int CT_TOP = VALID_BIT - 1;

    always_comb begin
        rdata = '0;
        if (addr[1:0] == 2'b00) begin
            case (csr_word_e'(addr[4:2]))
                W_DETECT: begin
                    rdata[NK-1:0]        = det_q;
                    rdata[CT_TOP -: TW]  = cap_ctype;
                    rdata[VALID_BIT]     = cap_valid;
                end
                W_DISABLE: rdata[NK-1:0]            = dis_q;
                W_INTEN:   rdata[NK-1:0]            = inten_q;
                W_ATTR:    rdata[SRC_LSB +: SW]     = cap_src;
                W_ADDRHI:  rdata[HI_W-1:0]          = cap_addr[AW-1:32];
                W_ADDRLO:  rdata                    = cap_addr[31:0];
                W_ATTR2:   rdata[NK-1:0]            = cap_lane;
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/icx_err_capture.sv
module icx_err_capture
    import icx_err_pkg::*;
#(
    parameter int NK = 4,
    parameter int AW = 40,
    parameter int SW = 8,
    parameter int TW = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NK-1:0]    ev_hit,
    input  logic [NK*AW-1:0] ev_addr,
    input  logic [NK*SW-1:0] ev_src,
    input  logic [NK*TW-1:0] ev_ctype,
    input  logic [4:0]       csr_addr,
    input  logic             csr_we,
    input  logic [CSR_W-1:0] csr_wdata,
    output logic [CSR_W-1:0] csr_rdata,
    output logic             err_irq
);
    logic [NK-1:0] det_q, dis_q, inten_q, cap_lane, sel, live;
    logic          cap_valid, found;
    logic [AW-1:0] cap_addr, pick_addr;
    logic [SW-1:0] cap_src, pick_src;
    logic [TW-1:0] cap_ctype, pick_ctype;
    csr_wr_t       wr;

    assign wr   = decode_write(csr_we, csr_addr);
    assign live = ev_hit & ~dis_q;

    icx_err_prio #(.NK(NK), .AW(AW), .SW(SW), .TW(TW)) prio_i (
        .live       (live),
        .lane_addr  (ev_addr),
        .lane_src   (ev_src),
        .lane_ctype (ev_ctype),
        .found      (found),
        .sel        (sel),
        .pick_addr  (pick_addr),
        .pick_src   (pick_src),
        .pick_ctype (pick_ctype)
    );

    icx_err_regs #(.NK(NK), .AW(AW), .SW(SW), .TW(TW)) regs_i (
        .clk          (clk),
        .rst          (rst),
        .live         (live),
        .wr           (wr),
        .wr_bits      (csr_wdata[NK-1:0]),
        .wr_valid_bit (csr_wdata[VALID_BIT]),
        .found        (found),
        .sel          (sel),
        .pick_addr    (pick_addr),
        .pick_src     (pick_src),
        .pick_ctype   (pick_ctype),
        .det_q        (det_q),
        .dis_q        (dis_q),
        .inten_q      (inten_q),
        .cap_valid    (cap_valid),
        .cap_addr     (cap_addr),
        .cap_src      (cap_src),
        .cap_ctype    (cap_ctype),
        .cap_lane     (cap_lane)
    );

    icx_err_rdmux #(.NK(NK), .AW(AW), .SW(SW), .TW(TW)) rdmux_i (
        .addr      (csr_addr),
        .det_q     (det_q),
        .dis_q     (dis_q),
        .inten_q   (inten_q),
        .cap_valid (cap_valid),
        .cap_addr  (cap_addr),
        .cap_src   (cap_src),
        .cap_ctype (cap_ctype),
        .cap_lane  (cap_lane),
        .rdata     (csr_rdata)
    );

    assign err_irq = |(det_q & inten_q);

endmodule

// File: rtl/icx_err_capture_chk.sv
module icx_err_capture_chk #(
    parameter int NK = 4,
    parameter int AW = 40,
    parameter int SW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [NK-1:0] ev_hit,
    input logic          csr_we,
    input logic [4:0]    csr_addr,
    input logic [31:0]   csr_wdata,
    input logic [NK-1:0] det_q,
    input logic [NK-1:0] dis_q,
    input logic          cap_valid,
    input logic [AW-1:0] cap_addr,
    input logic [SW-1:0] cap_src,
    input logic          err_irq
);
    logic det_write;
    assign det_write = csr_we && (csr_addr == 5'h00);

    AST_DETECT_SETS: assert property (@(posedge clk) disable iff (rst)
        ((ev_hit & ~dis_q) != '0) |=> ((det_q & $past(ev_hit & ~dis_q)) == $past(ev_hit & ~dis_q))); // R2

    AST_DETECT_STICKY: assert property (@(posedge clk) disable iff (rst)
        !det_write |=> ((det_q & $past(det_q)) == $past(det_q))); // R2

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
        ((ev_hit & dis_q & ~det_q) != '0) |=> ((det_q & $past(ev_hit & dis_q & ~det_q)) == '0)); // R3

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        err_irq |-> (det_q != '0)); // R4

    AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (cap_valid && !(det_write && csr_wdata[31])) |=> (cap_valid && $stable(cap_addr) && $stable(cap_src))); // R6

    AST_VALID_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        $rose(cap_valid) |-> $past((ev_hit & ~dis_q) != '0)); // R6

endmodule

bind icx_err_capture icx_err_capture_chk #(.NK(NK), .AW(AW), .SW(SW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .ev_hit    (ev_hit),
    .csr_we    (csr_we),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .det_q     (det_q),
    .dis_q     (dis_q),
    .cap_valid (cap_valid),
    .cap_addr  (cap_addr),
    .cap_src   (cap_src),
    .err_irq   (err_irq)
);

// File: tb/icx_err_capture_tb_top.sv
module icx_err_capture_tb_top;
    localparam int NK = 4, AW = 40, SW = 8, TW = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NK-1:0]    ev_hit = '0;
    logic [NK*AW-1:0] ev_addr;
    logic [NK*SW-1:0] ev_src;
    logic [NK*TW-1:0] ev_ctype;
    logic [4:0]       csr_addr = '0;
    logic             csr_we = 1'b0;
    logic [31:0]      csr_wdata = '0;
    logic [31:0]      csr_rdata;
    logic             err_irq;

    always #5 clk = ~clk;

    icx_err_capture #(.NK(NK), .AW(AW), .SW(SW), .TW(TW)) dut_i (.*);

    int  n_chk = 0, n_bad = 0, seed = 0;
    bit  done = 0;

    logic [3:0]  m_det, m_dis, m_en, m_lane;
    logic        m_val;
    logic [39:0] m_addr;
    logic [7:0]  m_src;
    logic [4:0]  m_ct;

    function automatic logic [39:0] l_addr(int i, int s);
        return {8'(8'hA0 + i + s), 32'(32'h1000_0000 * (i + 1) + s * 3)};
    endfunction
    function automatic logic [7:0] l_src(int i, int s);
        return 8'(8'h11 * (i + 1) + s);
    endfunction
    function automatic logic [4:0] l_ct(int i, int s);
        return 5'(i * 7 + s + 1);
    endfunction

    task automatic set_lanes(int s);
        seed = s;
        for (int i = 0; i < NK; i++) begin
            ev_addr[i*AW +: AW]  = l_addr(i, s);
            ev_src[i*SW +: SW]   = l_src(i, s);
            ev_ctype[i*TW +: TW] = l_ct(i, s);
        end
    endtask

    function automatic logic [31:0] m_read(logic [4:0] a);
        logic [31:0] r;
        r = '0;
        if (a[1:0] == 2'b00) begin
            case (a[4:2])
                3'd0: r = {m_val, m_ct, 22'd0, m_det};
                3'd1: r = {28'd0, m_dis};
                3'd2: r = {28'd0, m_en};
                3'd3: r = {6'd0, m_src, 18'd0};
                3'd4: r = {24'd0, m_addr[39:32]};
                3'd5: r = m_addr[31:0];
                3'd6: r = {28'd0, m_lane};
                default: r = '0;
            endcase
        end
        return r;
    endfunction

    task automatic m_reset();
        m_det = 0; m_dis = 0; m_en = 0; m_lane = 0;
        m_val = 0; m_addr = 0; m_src = 0; m_ct = 0;
    endtask

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic check_now(string tag);
        cmp({tag, " irq"}, {31'd0, err_irq}, {31'd0, |(m_det & m_en)});
        cmp({tag, " rdata"}, csr_rdata, m_read(csr_addr));
    endtask

    task automatic step(logic [3:0] kinds, logic we, logic [4:0] a, logic [31:0] wd, string tag);
        logic [3:0] live, clr, n_det;
        logic       cv;
        live = kinds & ~m_dis;
        clr  = (we && a == 5'h00) ? wd[3:0] : 4'd0;
        cv   = we && a == 5'h00 && wd[31];
        ev_hit = kinds; csr_we = we; csr_addr = a; csr_wdata = wd;
        @(posedge clk); #1;
        if ((!m_val || cv) && live != 0) begin
            for (int i = NK - 1; i >= 0; i--)
                if (live[i]) begin
                    m_addr = l_addr(i, seed); m_src = l_src(i, seed);
                    m_ct = l_ct(i, seed); m_lane = 4'(1 << i);
                end
            m_val = 1;
        end else if (cv) m_val = 0;
        n_det = (m_det & ~clr) | live;
        m_det = n_det;
        if (we && a == 5'h04) m_dis = wd[3:0];
        if (we && a == 5'h08) m_en  = wd[3:0];
        ev_hit = 0; csr_we = 0;
        #1;
        check_now(tag);
    endtask

    task automatic read_all(string tag);
        for (int w = 0; w < 8; w++) begin
            csr_addr = 5'(w * 4);
            #1;
            cmp(tag, csr_rdata, m_read(csr_addr));
        end
        csr_addr = 5'h01;
        #1;
        cmp({tag, " R9 misaligned"}, csr_rdata, 32'd0);
    endtask

    task automatic do_reset();
        rst = 1;
        @(posedge clk); @(posedge clk); #1;
        rst = 0;
        m_reset();
        check_now("R1 reset");
        read_all("R1 reset words");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        set_lanes(0);
        m_reset();
        do_reset();

        step(4'b0000, 1, 5'h08, 32'h0000_000F, "R4 enable all");
        step(4'b0010, 0, 5'h00, 0, "R2 R6 single coherency");
        read_all("R6 R8 record after first event");
        set_lanes(5);
        step(4'b1000, 0, 5'h14, 0, "R6 later event frozen");
        read_all("R6 R8 record unchanged");
        step(4'b0000, 1, 5'h00, 32'h0000_0002, "R5 clear bit1 only");
        read_all("R5 valid kept");
        step(4'b0000, 1, 5'h00, 32'h8000_0008, "R5 clear all");
        read_all("R5 cleared");
        step(4'b1100, 0, 5'h00, 0, "R7 two lanes same cycle");
        read_all("R7 lane2 wins");
        step(4'b1111, 0, 5'h18, 0, "R7 all lanes while frozen");
        set_lanes(9);
        step(4'b0001, 1, 5'h00, 32'h8000_000F, "R5 R6 clear meets event");
        read_all("R5 R6 new capture lane0");
        step(4'b0000, 1, 5'h00, 32'h8000_000F, "R5 clear");
        step(4'b0000, 1, 5'h04, 32'hFFFF_FFF1, "R3 R9 disable lane0");
        step(4'b0001, 0, 5'h00, 0, "R3 masked lane0 ignored");
        read_all("R3 no capture");
        step(4'b0011, 0, 5'h0C, 0, "R3 R7 lane1 captured over masked lane0");
        read_all("R3 R8 lane1 record");
        step(4'b0000, 1, 5'h08, 32'h0, "R4 interrupt off");
        step(4'b0100, 0, 5'h00, 0, "R4 detection still on");
        step(4'b0000, 1, 5'h08, 32'h0000_0008, "R4 enable stash only");
        step(4'b1000, 0, 5'h08, 0, "R4 stash raises irq");
        r = m_read(5'h14);
        step(4'b0000, 1, 5'h14, 32'hDEAD_BEEF, "R9 addr low write ignored");
        step(4'b0000, 1, 5'h0C, 32'hFFFF_FFFF, "R9 attr write ignored");
        step(4'b0000, 1, 5'h10, 32'hFFFF_FFFF, "R9 addr high write ignored");
        step(4'b0000, 1, 5'h18, 32'hFFFF_FFFF, "R9 attr2 write ignored");
        step(4'b0000, 1, 5'h1C, 32'hFFFF_FFFF, "R9 unmapped write ignored");
        step(4'b0000, 1, 5'h09, 32'hFFFF_FFFF, "R9 misaligned write ignored");
        csr_addr = 5'h14; #1;
        cmp("R9 addr low kept", csr_rdata, r);
        read_all("R9 words after ignored writes");

        begin
            logic [31:0] lf;
            logic [4:0]  a;
            lf = 32'h1D2C_3B4A;
            for (int n = 0; n < 600; n++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                if (n % 32 == 0) set_lanes(n / 32 + 20);
                a = 5'({lf[14:12], 2'b00});
                if (lf[16]) a[0] = 1'b1;
                if (lf[17] && lf[18]) a = 5'h00;
                step(lf[3:0] & lf[7:4], lf[10:8] < 3'd3, a,
                     {lf[20], 27'd0, lf[27:24]}, "R2 R5 R6 R7 mixed");
            end
        end
        read_all("R8 words after mixed run");
        do_reset();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule